// File: doc/BRIEF.md
# Isochronous DMA Termination Controller

This block decides when a DMA burst to or from an isochronous USB endpoint ends. Software loads a transfer length, chooses whether the length may stop the burst, and states whether the endpoint is an IN or an OUT endpoint. A burst starts when software sets the enable bit. While the burst runs, the block raises a word request every cycle and counts down once for each word the DMA side accepts.

A burst ends for one of three reasons:
- software clears the enable bit;
- the USB side reports an end of packet;
- the word count runs out. This reason applies only to IN endpoints with the length stop switched on. For OUT endpoints the block ignores the count, because an OUT packet may be shorter than the programmed length.

When a burst ends, the block gives a one-cycle end-of-transfer pulse and latches a cause code. The code stays readable until the next burst starts.

The block also clears the enable bit by itself after the count and end-of-packet stops. Software therefore sees a single enable bit that is always 1 exactly while a burst is in progress.

Top module: `isoc_dma_stop`

## Requirements
- R1: After reset, `dma_en`, `xfer_active`, `word_req` and `eot_pulse` are 0, `words_left` is 0 and `eot_cause` is 00.
- R2: A write of 1 through `ctl_en_wr`/`ctl_en_val` while `dma_en` is 0 makes the following outputs take effect from the next clock: `dma_en`, `xfer_active` and `word_req` become 1, `words_left` takes the value of `cfg_xfer_len`, and `eot_cause` becomes 00. A write of 1 during a burst has no effect.
- R3: Each cycle with `word_ack` high during a burst lowers `words_left` by one. The count stays at 0 once it reaches 0.
- R4: When `cfg_ep_in`=1 and `cfg_len_stop_en`=1, a burst stops in the cycle in which an accepted word takes `words_left` from 1 to 0. It also stops in its first cycle if `words_left` is 0. The stop gives cause 01.
- R5: When `cfg_ep_in`=0 (OUT), the count never stops a burst, even with `cfg_len_stop_en`=1. The burst stays active with `words_left` at 0.
- R6: When `cfg_len_stop_en`=0, the count never stops a burst on either direction.
- R7: `usb_eop` high during a burst stops it with cause 10, whatever the remaining count.
- R8: A write of 0 through `ctl_en_wr`/`ctl_en_val` during a burst stops it with cause 11.
- R9: When several stop reasons occur in the same cycle, the cause follows this priority: disable (11) first, then end of packet (10), then count (01).
- R10: A stop gives `eot_pulse` for exactly one clock. It starts in the clock after the stop reason. In that same clock, `xfer_active`, `word_req` and `dma_en` are already 0.
- R11: `eot_cause` holds its value from the stop until the next start. While idle, `usb_eop` and writes of 0 produce no pulse and leave the cause unchanged.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Synchronous reset, active low |
| cfg_xfer_len | input | CNT_W | Programmed word count, loaded at start |
| cfg_len_stop_en | input | 1 | 1 lets the count stop the burst |
| cfg_ep_in | input | 1 | Endpoint direction: 1 = IN, 0 = OUT |
| ctl_en_wr | input | 1 | Software write strobe for the enable bit |
| ctl_en_val | input | 1 | Value written to the enable bit |
| usb_eop | input | 1 | End-of-packet indication from the USB side |
| word_ack | input | 1 | DMA side accepted one word this cycle |
| dma_en | output | 1 | Current value of the enable bit |
| xfer_active | output | 1 | Burst in progress |
| word_req | output | 1 | Word request strobe |
| words_left | output | CNT_W | Remaining word count |
| eot_pulse | output | 1 | One-cycle end-of-transfer pulse |
| eot_cause | output | 2 | Stop cause: 00 none, 01 count, 10 end of packet, 11 disable |

## Verification
The assertions rely on two conditions on the inputs:
- `word_ack` is high only in cycles where `word_req` is high.
- `cfg_xfer_len`, `cfg_len_stop_en` and `cfg_ep_in` do not change during a burst.

The stimulus keeps to both. Each random burst picks its length, direction and stop enable before the start write and holds them until the end pulse. The bench draws acknowledges only while its own model says a burst is active. The idle-cycle cases for R11 use only end-of-packet and writes of 0, never acknowledges.

// File: rtl/isoc_dma_pkg.sv
package isoc_dma_pkg;

  typedef enum logic [1:0] {
    CAUSE_NONE    = 2'b00,
    CAUSE_COUNT   = 2'b01,
    CAUSE_EOP     = 2'b10,
    CAUSE_DISABLE = 2'b11
  } stop_cause_e;

  // Priority pick: disable, then end of packet, then count.
  function automatic stop_cause_e pick_cause(input logic dis, input logic eop, input logic cnt);
    if (dis)      return CAUSE_DISABLE;
    else if (eop) return CAUSE_EOP;
    else if (cnt) return CAUSE_COUNT;
    else          return CAUSE_NONE;
  endfunction

endpackage

// File: rtl/iso_enable_reg.sv
module iso_enable_reg (
  input  logic clk,
  input  logic rst_n,
  input  logic wr,
  input  logic wdata,
  input  logic auto_clr,
  output logic en,
  output logic start,
  output logic dis_req
);

  logic en_q;

  assign start   = wr && wdata && !en_q;
  assign dis_req = wr && !wdata && en_q;
  assign en      = en_q;

  always_ff @(posedge clk) begin
    if (!rst_n)                  en_q <= 1'b0;
    else if (start)              en_q <= 1'b1;
    else if (dis_req || auto_clr) en_q <= 1'b0;
  end

  // R2
  start_sets_en_chk: assert property (@(posedge clk) disable iff (!rst_n)
    start |=> en_q);

  // R10
  auto_clr_drops_en_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (auto_clr && !start) |=> !en_q);

endmodule

// File: rtl/iso_word_counter.sv
module iso_word_counter #(
  parameter int CNT_W = 16
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             load,
  input  logic [CNT_W-1:0] load_val,
  input  logic             dec,
  output logic [CNT_W-1:0] count,
  output logic             expire
);

  localparam logic [CNT_W-1:0] ZERO = '0;
  localparam logic [CNT_W-1:0] ONE  = {{(CNT_W-1){1'b0}}, 1'b1};

  function automatic logic [CNT_W-1:0] dec_sat(input logic [CNT_W-1:0] v);
    return (v == ZERO) ? v : v - ONE;
  endfunction

  logic [CNT_W-1:0] cnt_q;

  always_ff @(posedge clk) begin
    if (!rst_n)    cnt_q <= ZERO;
    else if (load) cnt_q <= load_val;
    else if (dec)  cnt_q <= dec_sat(cnt_q);
  end

  assign count  = cnt_q;
  assign expire = (cnt_q == ZERO) || (dec && cnt_q == ONE);

  // R3
  count_dec_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (dec && !load && cnt_q != ZERO) |=> cnt_q == $past(cnt_q) - ONE);

  // R3
  count_floor_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (dec && !load && cnt_q == ZERO) |=> cnt_q == ZERO);

  // R2
  count_load_chk: assert property (@(posedge clk) disable iff (!rst_n)
    load |=> cnt_q == $past(load_val));

endmodule

// File: rtl/iso_stop_arbiter.sv
module iso_stop_arbiter
  import isoc_dma_pkg::*;
(
  input  logic        clk,
  input  logic        rst_n,
  input  logic        start,
  input  logic        dis_req,
  input  logic        eop,
  input  logic        cnt_expire,
  input  logic        ep_in,
  input  logic        len_stop_en,
  output logic        active,
  output logic        stop,
  output logic        eot_pulse,
  output stop_cause_e cause
);

  logic        active_q, pulse_q;
  stop_cause_e cause_q, cause_sel;
  logic        hit_dis, hit_eop, hit_cnt;

  assign hit_dis   = active_q && dis_req;
  assign hit_eop   = active_q && eop;
  assign hit_cnt   = active_q && cnt_expire && ep_in && len_stop_en;
  assign stop      = hit_dis || hit_eop || hit_cnt;
  assign cause_sel = pick_cause(hit_dis, hit_eop, hit_cnt);

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      active_q <= 1'b0;
      pulse_q  <= 1'b0;
      cause_q  <= CAUSE_NONE;
    end else begin
      pulse_q <= stop;
      if (start) begin
        active_q <= 1'b1;
        cause_q  <= CAUSE_NONE;
      end else if (stop) begin
        active_q <= 1'b0;
        cause_q  <= cause_sel;
      end
    end
  end

  assign active    = active_q;
  assign eot_pulse = pulse_q;
  assign cause     = cause_q;

  // R10
  eot_one_cycle_chk: assert property (@(posedge clk) disable iff (!rst_n)
    pulse_q |=> !pulse_q);

  // R10
  stop_drops_active_chk: assert property (@(posedge clk) disable iff (!rst_n)
    stop |=> (pulse_q && !active_q));

  // R5
  out_no_count_stop_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (active_q && !ep_in && !eop && !dis_req) |=> (!pulse_q && active_q));

  // R8
  disable_first_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (active_q && dis_req) |=> cause_q == CAUSE_DISABLE);

  // R11
  cause_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (!start && !stop) |=> $stable(cause_q));

endmodule

// File: rtl/isoc_dma_stop.sv
module isoc_dma_stop
  import isoc_dma_pkg::*;
#(
  parameter int CNT_W = 16
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic [CNT_W-1:0] cfg_xfer_len,
  input  logic             cfg_len_stop_en,
  input  logic             cfg_ep_in,
  input  logic             ctl_en_wr,
  input  logic             ctl_en_val,
  input  logic             usb_eop,
  input  logic             word_ack,
  output logic             dma_en,
  output logic             xfer_active,
  output logic             word_req,
  output logic [CNT_W-1:0] words_left,
  output logic             eot_pulse,
  output logic [1:0]       eot_cause
);

  logic        start_w, dis_w, stop_w, active_w, expire_w, dec_w, en_w;
  stop_cause_e cause_w;

  assign dec_w = word_ack && active_w;

  iso_enable_reg u_en (
    .clk      (clk),
    .rst_n    (rst_n),
    .wr       (ctl_en_wr),
    .wdata    (ctl_en_val),
    .auto_clr (stop_w),
    .en       (en_w),
    .start    (start_w),
    .dis_req  (dis_w)
  );

  iso_word_counter #(.CNT_W(CNT_W)) u_cnt (
    .clk      (clk),
    .rst_n    (rst_n),
    .load     (start_w),
    .load_val (cfg_xfer_len),
    .dec      (dec_w),
    .count    (words_left),
    .expire   (expire_w)
  );

  iso_stop_arbiter u_arb (
    .clk         (clk),
    .rst_n       (rst_n),
    .start       (start_w),
    .dis_req     (dis_w),
    .eop         (usb_eop),
    .cnt_expire  (expire_w),
    .ep_in       (cfg_ep_in),
    .len_stop_en (cfg_len_stop_en),
    .active      (active_w),
    .stop        (stop_w),
    .eot_pulse   (eot_pulse),
    .cause       (cause_w)
  );

  assign dma_en      = en_w;
  assign xfer_active = active_w;
  assign word_req    = active_w;
  assign eot_cause   = cause_w;

  // R10
  en_tracks_active_chk: assert property (@(posedge clk) disable iff (!rst_n)
    en_w == active_w);

  // R7
  eop_stop_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (active_w && usb_eop && !dis_w) |=> (eot_pulse && cause_w == CAUSE_EOP));

endmodule

// File: tb/sim_isoc_dma_stop.sv
module sim_isoc_dma_stop;
  localparam int CNT_W = 8;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic [CNT_W-1:0] cfg_xfer_len = '0;
  logic cfg_len_stop_en = 1'b0, cfg_ep_in = 1'b0;
  logic ctl_en_wr = 1'b0, ctl_en_val = 1'b0, usb_eop = 1'b0, word_ack = 1'b0;
  logic dma_en, xfer_active, word_req, eot_pulse;
  logic [CNT_W-1:0] words_left;
  logic [1:0] eot_cause;

  int checks = 0, fails = 0;
  bit done = 1'b0;

  // bench model state
  bit m_act = 1'b0, m_pulse = 1'b0;
  int m_cnt = 0;
  int m_cause = 0;

  always #4 clk = ~clk;

  isoc_dma_stop #(.CNT_W(CNT_W)) u0 (.*);

  task automatic chk(string tag, int act, int exp);
    checks++;
    if (act != exp) begin
      fails++;
      $display("FAIL %s: actual %0d expected %0d at %0t", tag, act, exp, $time);
    end
  endtask

  function automatic int cause_of(bit dis, bit eop, bit cnt);
    return dis ? 3 : eop ? 2 : cnt ? 1 : 0;
  endfunction

  task automatic model_step();
    bit dis, eop, cnt;
    if (!rst_n) begin
      m_act = 0; m_pulse = 0; m_cnt = 0; m_cause = 0;
      return;
    end
    m_pulse = 0;
    if (m_act) begin
      dis = ctl_en_wr && !ctl_en_val;
      eop = usb_eop;
      cnt = cfg_ep_in && cfg_len_stop_en && (m_cnt == 0 || (word_ack && m_cnt == 1));
      if (word_ack && m_cnt > 0) m_cnt--;
      if (dis || eop || cnt) begin
        m_act = 0; m_pulse = 1; m_cause = cause_of(dis, eop, cnt);
      end
    end else if (ctl_en_wr && ctl_en_val) begin
      m_act = 1; m_cnt = int'(cfg_xfer_len); m_cause = 0;
    end
  endtask

  task automatic compare_all();
    chk("R2 xfer_active", int'(xfer_active), int'(m_act));
    chk("R10 word_req", int'(word_req), int'(m_act));
    chk("R10 dma_en", int'(dma_en), int'(m_act));
    chk("R3 words_left", int'(words_left), m_cnt);
    chk("R10 eot_pulse", int'(eot_pulse), int'(m_pulse));
    chk("R9 eot_cause", int'(eot_cause), m_cause);
  endtask

  task automatic cyc(bit wr, bit wd, bit e, bit a);
    @(negedge clk);
    ctl_en_wr = wr; ctl_en_val = wd; usb_eop = e; word_ack = a;
    @(posedge clk);
    model_step();
    #2;
    compare_all();
  endtask

  task automatic setup(int len, bit dir_in, bit len_en);
    @(negedge clk);
    cfg_xfer_len = CNT_W'(len); cfg_ep_in = dir_in; cfg_len_stop_en = len_en;
  endtask

  initial begin
    repeat (3) @(posedge clk);
    model_step();
    #2;
    // R1 reset state
    chk("R1 dma_en", int'(dma_en), 0);
    chk("R1 xfer_active", int'(xfer_active), 0);
    chk("R1 eot_cause", int'(eot_cause), 0);
    chk("R1 words_left", int'(words_left), 0);
    @(negedge clk); rst_n = 1'b1;

    // R2 start, R3 count, R4 count stop on IN
    setup(3, 1, 1);
    cyc(1, 1, 0, 0);
    chk("R2 load", int'(words_left), 3);
    cyc(1, 1, 0, 1);             // write 1 while running: no effect
    chk("R2 rewrite ignored", int'(words_left), 2);
    cyc(0, 0, 0, 1);
    cyc(0, 0, 0, 1);
    chk("R4 pulse", int'(eot_pulse), 1);
    chk("R4 cause", int'(eot_cause), 1);
    chk("R10 req low", int'(word_req), 0);
    cyc(0, 0, 0, 0);
    chk("R10 single pulse", int'(eot_pulse), 0);

    // R11 idle: eop and write 0 do nothing
    cyc(0, 0, 1, 0);
    cyc(1, 0, 0, 0);
    chk("R11 no pulse", int'(eot_pulse), 0);
    chk("R11 cause held", int'(eot_cause), 1);

    // R5 OUT ignores count, then R7 eop stop
    setup(2, 0, 1);
    cyc(1, 1, 0, 0);
    chk("R11 cause cleared", int'(eot_cause), 0);
    repeat (4) cyc(0, 0, 0, 1);
    chk("R5 still active", int'(xfer_active), 1);
    chk("R5 floor", int'(words_left), 0);
    cyc(0, 0, 1, 0);
    chk("R7 cause", int'(eot_cause), 2);

    // R6 length stop off, then R8 disable
    setup(1, 1, 0);
    cyc(1, 1, 0, 0);
    repeat (3) cyc(0, 0, 0, 1);
    chk("R6 still active", int'(xfer_active), 1);
    cyc(1, 0, 0, 0);
    chk("R8 cause", int'(eot_cause), 3);
    chk("R8 en cleared", int'(dma_en), 0);

    // R9 priorities
    setup(1, 1, 1);
    cyc(1, 1, 0, 0);
    cyc(1, 0, 1, 1);
    chk("R9 disable wins", int'(eot_cause), 3);
    cyc(1, 1, 0, 0);
    cyc(0, 0, 1, 1);
    chk("R9 eop over count", int'(eot_cause), 2);

    // R4 zero length stops at once
    setup(0, 1, 1);
    cyc(1, 1, 0, 0);
    cyc(0, 0, 0, 0);
    chk("R4 zero length", int'(eot_cause), 1);

    // random bursts
    void'($urandom(32'h1234_5678));
    for (int t = 0; t < 300; t++) begin
      setup(int'($urandom_range(0, 9)), bit'($urandom_range(0, 1)), bit'($urandom_range(0, 1)));
      cyc(1, 1, 0, 0);
      for (int k = 0; k < 40 && m_act; k++) begin
        bit a, e, d;
        a = ($urandom_range(0, 3) != 0);
        e = ($urandom_range(0, 15) == 0);
        d = ($urandom_range(0, 19) == 0);
        cyc(d, 1'b0, e, a);
      end
      if (m_act) cyc(1, 0, 0, 0);
      cyc(0, 0, 0, 0);
    end

    if (!done) begin
      done = 1'b1;
      $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
      $finish;
    end
  end

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      done = 1'b1;
      fails++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
      $finish;
    end
  end

endmodule